// File: doc/BRIEF.md
# Byte-Masked Dual-Port Synchronous RAM

This block is an on-chip synchronous memory whose writes can be limited to chosen byte lanes. A shared four-bit lane-select bus decides which lanes of the write data land in the array. The lane grouping follows the data width. Words of 9 bits or fewer form a single lane. Widths 16 and 32 split into 8-bit lanes. Widths 18 and 36, which carry a parity bit per lane, split into 9-bit lanes.

With `DUAL` set, the block offers two independent read/write ports. The low half of the lane-select bus serves port A and the high half serves port B, so each port is limited to 18 bits. With `DUAL` clear, port A alone owns all four select bits and port B is inert.

All write controls are captured at a clock edge together with the address and data. The array is updated one edge later. Each port reads every cycle from its captured address, and the data appears after that same later edge. On a write cycle, the read output of the writing port shows the new data in the enabled lanes. The masked lanes of that output carry no defined value.

Top module: `bytemask_dpram`

## Requirements
- R1: At widths 16 and 32, lanes are 8 bits wide: select bit k writes data bits 8k+7 down to 8k.
- R2: At widths 18 and 36, lanes are 9 bits wide: select bit k writes data bits 9k+8 down to 9k.
- R3: At widths of 9 bits or fewer, a whole word is written only when both the port's write enable and its single select bit are high. That select bit is bit 0 for port A and, in dual mode, bit 2 for port B.
- R4: In dual mode, port A lanes take select bits 1:0 and port B lanes take bits 3:2. Both ports may write different addresses in the same cycle.
- R5: A lane whose select bit is low during a write keeps its stored contents.
- R6: With a port's write enable low, nothing is written through that port, whatever the select bits are.
- R7: Write enable, select bits, address and data are captured at a clock edge. The read data for a captured address appears after the following edge, and later input changes do not alter a captured operation.
- R8: On a write cycle, the writing port's output shows the new data in enabled lanes; masked lanes of that output are don't-care.
- R9: While the reset input is low, both read outputs are zero and no write reaches the array. Reset release is synchronised to the clock.
- R10: In single-port mode, port B inputs are ignored and the port B read output stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_be | input | 4 | Shared lane-select bus |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |

## Verification
On every cycle the assertions check four things:
- the enabled lanes of a writing port's output equal the captured write data;
- the port A output holds still while its captured address is unchanged and neither port writes;
- the outputs stay at zero during reset;
- the inert port B output stays at zero in single-port mode.

Lane geometry, preservation of masked lanes, the split of the select bus between ports and the effect of a low write enable can only be shown by the bench's scenarios. These scenarios write a word and read it back against a shadow model. They drive the same stimulus into an 18-bit dual-port, a 32-bit single-port and a 9-bit dual-port configuration.

// File: rtl/bmram_pkg.sv
package bmram_pkg;

  // Width of the shared lane-select bus.
  localparam int SEL_W = 4;

  // Lane width for a given data width: one lane for narrow words,
  // 9-bit lanes when each lane carries parity, else 8-bit lanes.
  function automatic int lane_width(input int dw);
    if (dw <= 9)
      return dw;
    else if ((dw % 9) == 0)
      return 9;
    else
      return 8;
  endfunction

  function automatic int lane_count(input int dw);
    return dw / lane_width(dw);
  endfunction

endpackage

// File: rtl/bmram_rst_sync.sv
module bmram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sync_q <= '0;
    else
      sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/bmram_port_reg.sv
module bmram_port_reg #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  sel_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  sel_o
);

  logic              we_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [LANES-1:0]  sel_d;

  // Next-state: capture when enabled, otherwise hold.
  always_comb begin
    if (cap_en) begin
      we_d    = we_i;
      addr_d  = addr_i;
      wdata_d = wdata_i;
      sel_d   = sel_i;
    end else begin
      we_d    = we_o;
      addr_d  = addr_o;
      wdata_d = wdata_o;
      sel_d   = sel_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      sel_o   <= '0;
    end else begin
      we_o    <= we_d;
      addr_o  <= addr_d;
      wdata_o <= wdata_d;
      sel_o   <= sel_d;
    end
  end

endmodule

// File: rtl/bmram_lane_mask.sv
module bmram_lane_mask #(
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic [LANES-1:0]  sel,
  output logic [DATA_W-1:0] mask
);

  localparam int LANE_W = DATA_W / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask[l*LANE_W +: LANE_W] = {LANE_W{sel[l]}};
  end

endmodule

// File: rtl/bmram_core.sv
module bmram_core #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18,
  parameter bit DUAL   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  input  logic [DATA_W-1:0] mask_a,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  input  logic [DATA_W-1:0] mask_b,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_a;
  logic [DATA_W-1:0] q_a_d;

  // Array update: bitwise masked, no reset on storage.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DATA_W; i++) begin
      if (wr_a && mask_a[i])
        mem[addr_a][i] <= wdata_a[i];
      if (wr_b && mask_b[i])
        mem[addr_b][i] <= wdata_b[i];
    end
  end

  // Port A output next-state: new data in enabled lanes on a write,
  // undefined in masked lanes, stored word otherwise.
  always_comb begin
    rd_a = mem[addr_a];
    for (int i = 0; i < DATA_W; i++)
      q_a_d[i] = wr_a ? (mask_a[i] ? wdata_a[i] : 1'bx) : rd_a[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_a <= '0;
    else
      q_a <= q_a_d;
  end

  if (DUAL) begin : g_port_b
    logic [DATA_W-1:0] rd_b;
    logic [DATA_W-1:0] q_b_d;
    logic [DATA_W-1:0] q_b_r;

    always_comb begin
      rd_b = mem[addr_b];
      for (int i = 0; i < DATA_W; i++)
        q_b_d[i] = wr_b ? (mask_b[i] ? wdata_b[i] : 1'bx) : rd_b[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q_b_r <= '0;
      else
        q_b_r <= q_b_d;
    end

    assign q_b = q_b_r;
  end else begin : g_no_port_b
    assign q_b = '0;
  end

endmodule

// File: rtl/bytemask_dpram.sv
module bytemask_dpram
  import bmram_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  parameter bit DUAL   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  wr_be,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int LANES = lane_count(DATA_W);

  logic              core_rst_n;
  logic [LANES-1:0]  a_sel_in;
  logic [LANES-1:0]  b_sel_in;
  logic              b_cap_en;

  logic              a_we_q;
  logic [ADDR_W-1:0] a_addr_q;
  logic [DATA_W-1:0] a_wdata_q;
  logic [LANES-1:0]  a_sel_q;
  logic [DATA_W-1:0] a_mask;

  logic              b_we_q;
  logic [ADDR_W-1:0] b_addr_q;
  logic [DATA_W-1:0] b_wdata_q;
  logic [LANES-1:0]  b_sel_q;
  logic [DATA_W-1:0] b_mask;

  // Split of the shared select bus between the ports.
  if (DUAL) begin : g_dual_sel
    assign a_sel_in = wr_be[LANES-1:0];
    assign b_sel_in = wr_be[2 +: LANES];
    assign b_cap_en = 1'b1;
  end else begin : g_single_sel
    assign a_sel_in = wr_be[LANES-1:0];
    assign b_sel_in = '0;
    assign b_cap_en = 1'b0;
  end

  bmram_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  bmram_port_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_reg_a (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .cap_en  (1'b1),
    .we_i    (a_we),
    .addr_i  (a_addr),
    .wdata_i (a_wdata),
    .sel_i   (a_sel_in),
    .we_o    (a_we_q),
    .addr_o  (a_addr_q),
    .wdata_o (a_wdata_q),
    .sel_o   (a_sel_q)
  );

  bmram_port_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_reg_b (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .cap_en  (b_cap_en),
    .we_i    (b_we),
    .addr_i  (b_addr),
    .wdata_i (b_wdata),
    .sel_i   (b_sel_in),
    .we_o    (b_we_q),
    .addr_o  (b_addr_q),
    .wdata_o (b_wdata_q),
    .sel_o   (b_sel_q)
  );

  bmram_lane_mask #(.DATA_W(DATA_W), .LANES(LANES)) u_mask_a (
    .sel  (a_sel_q),
    .mask (a_mask)
  );

  bmram_lane_mask #(.DATA_W(DATA_W), .LANES(LANES)) u_mask_b (
    .sel  (b_sel_q),
    .mask (b_mask)
  );

  bmram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUAL(DUAL)) u_core (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_a    (a_we_q),
    .addr_a  (a_addr_q),
    .wdata_a (a_wdata_q),
    .mask_a  (a_mask),
    .wr_b    (b_we_q),
    .addr_b  (b_addr_q),
    .wdata_b (b_wdata_q),
    .mask_b  (b_mask),
    .q_a     (a_rdata),
    .q_b     (b_rdata)
  );

endmodule

// File: rtl/bytemask_dpram_chk.sv
module bytemask_dpram_chk #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  parameter bit DUAL   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_n,
  input logic [DATA_W-1:0] a_rdata,
  input logic [DATA_W-1:0] b_rdata,
  input logic              a_we_q,
  input logic [ADDR_W-1:0] a_addr_q,
  input logic [DATA_W-1:0] a_wdata_q,
  input logic [DATA_W-1:0] a_mask,
  input logic              b_we_q,
  input logic [DATA_W-1:0] b_wdata_q,
  input logic [DATA_W-1:0] b_mask
);

  // Set once a clock edge has seen the reset input low.
  logic rst_seen;
  always_ff @(posedge clk) begin
    rst_seen <= !rst_n;
  end

  always @(posedge clk) begin
    if (!rst_n && rst_seen)
      assert_reset_out_R9: assert (a_rdata == '0 && b_rdata == '0);
  end

  assert_rdw_lanes_a_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    a_we_q |=> ((a_rdata & $past(a_mask)) == ($past(a_wdata_q) & $past(a_mask))));

  assert_hold_out_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!a_we_q && !b_we_q && $past(!a_we_q && !b_we_q) && $stable(a_addr_q)
     && $past(core_rst_n)) |=> $stable(a_rdata));

  if (DUAL) begin : g_dual_chk
    assert_rdw_lanes_b_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
      b_we_q |=> ((b_rdata & $past(b_mask)) == ($past(b_wdata_q) & $past(b_mask))));
  end else begin : g_single_chk
    assert_b_idle_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
      b_we_q || (b_rdata == '0));
  end

endmodule

bind bytemask_dpram bytemask_dpram_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .DUAL   (DUAL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .a_rdata    (a_rdata),
  .b_rdata    (b_rdata),
  .a_we_q     (a_we_q),
  .a_addr_q   (a_addr_q),
  .a_wdata_q  (a_wdata_q),
  .a_mask     (a_mask),
  .b_we_q     (b_we_q),
  .b_wdata_q  (b_wdata_q),
  .b_mask     (b_mask)
);

// File: tb/test_bytemask_dpram.sv
`timescale 1ns/1ps
module test_bytemask_dpram;

  logic        clk;
  logic        rst_n;
  logic [3:0]  be;
  logic        a_we, b_we;
  logic [5:0]  a_addr, b_addr;
  logic [35:0] a_wd, b_wd;
  logic [17:0] qa18, qb18;
  logic [31:0] qa32, qb32;
  logic [8:0]  qa9, qb9;

  int n_chk;
  int n_err;
  bit done;

  logic [17:0] sh18 [64];
  logic [31:0] sh32 [64];
  logic [8:0]  sh9  [64];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  bytemask_dpram #(.DATA_W(18), .ADDR_W(6), .DUAL(1'b1)) i_bytemask_dpram (
    .clk(clk), .rst_n(rst_n), .wr_be(be),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wd[17:0]), .a_rdata(qa18),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wd[17:0]), .b_rdata(qb18)
  );

  bytemask_dpram #(.DATA_W(32), .ADDR_W(6), .DUAL(1'b0)) i_bytemask_dpram_w32 (
    .clk(clk), .rst_n(rst_n), .wr_be(be),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wd[31:0]), .a_rdata(qa32),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wd[31:0]), .b_rdata(qb32)
  );

  bytemask_dpram #(.DATA_W(9), .ADDR_W(6), .DUAL(1'b1)) i_bytemask_dpram_w9 (
    .clk(clk), .rst_n(rst_n), .wr_be(be),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wd[8:0]), .a_rdata(qa9),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wd[8:0]), .b_rdata(qb9)
  );

  // Lane masks computed from the requirements (R1, R2, R3, R4).
  function automatic logic [17:0] m18(input logic [1:0] s);
    return {{9{s[1]}}, {9{s[0]}}};
  endfunction
  function automatic logic [31:0] m32(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction
  function automatic logic [8:0] m9(input logic s);
    return {9{s}};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One write cycle; checks the read-on-write output (R8) and updates shadows.
  task automatic wr(input logic wa, input logic [5:0] aa, input logic [35:0] da,
                    input logic wb, input logic [5:0] ab, input logic [35:0] db,
                    input logic [3:0] s);
    logic [17:0] ma18, mb18;
    logic [31:0] ma32;
    logic [8:0]  ma9, mb9;
    ma18 = m18(s[1:0]); mb18 = m18(s[3:2]);
    ma32 = m32(s);
    ma9  = m9(s[0]);    mb9  = m9(s[2]);
    @(negedge clk);
    a_we = wa; a_addr = aa; a_wd = da;
    b_we = wb; b_addr = ab; b_wd = db; be = s;
    if (wa) begin
      sh18[aa] = (sh18[aa] & ~ma18) | (da[17:0] & ma18);
      sh32[aa] = (sh32[aa] & ~ma32) | (da[31:0] & ma32);
      sh9[aa]  = (sh9[aa]  & ~ma9)  | (da[8:0]  & ma9);
    end
    if (wb) begin
      sh18[ab] = (sh18[ab] & ~mb18) | (db[17:0] & mb18);
      sh9[ab]  = (sh9[ab]  & ~mb9)  | (db[8:0]  & mb9);
    end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0; be = 4'h0;
    a_wd = ~da; b_wd = ~db;
    @(negedge clk);
    if (wa) begin
      chk("R8", {18'h0, qa18 & ma18}, {18'h0, da[17:0] & ma18});
      chk("R8", {4'h0, qa32 & ma32}, {4'h0, da[31:0] & ma32});
      chk("R8", {27'h0, qa9 & ma9}, {27'h0, da[8:0] & ma9});
    end
    if (wb) begin
      chk("R8", {18'h0, qb18 & mb18}, {18'h0, db[17:0] & mb18});
      chk("R8", {27'h0, qb9 & mb9}, {27'h0, db[8:0] & mb9});
    end
  endtask

  // Read both ports and compare with the shadow memories.
  task automatic rd(input logic [5:0] aa, input logic [5:0] ab, input string req);
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0; a_addr = aa; b_addr = ab;
    @(negedge clk);
    @(negedge clk);
    chk(req, {18'h0, qa18}, {18'h0, sh18[aa]});
    chk(req, {18'h0, qb18}, {18'h0, sh18[ab]});
    chk(req, {4'h0, qa32}, {4'h0, sh32[aa]});
    chk(req, {27'h0, qa9}, {27'h0, sh9[aa]});
    chk(req, {27'h0, qb9}, {27'h0, sh9[ab]});
    chk("R10", {4'h0, qb32}, 36'h0);
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    chk("R9", {18'h0, qa18}, 36'h0);
    chk("R9", {18'h0, qb18}, 36'h0);
    chk("R9", {4'h0, qa32}, 36'h0);
    chk("R9", {27'h0, qb9}, 36'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_init;
    for (int i = 0; i < 32; i++)
      wr(1'b1, 6'(i), {6{6'(i)}} ^ 36'h5_A5A5_A5A5, 1'b0, 6'd0, 36'h0, 4'hF);
    rd(6'd0, 6'd31, "R8");
  endtask

  task automatic t_lane9;
    wr(1'b1, 6'd1, 36'hF_0F0F_0F0F, 1'b0, 6'd0, 36'h0, 4'b0010);
    rd(6'd1, 6'd0, "R2");
    wr(1'b1, 6'd1, 36'h3_3333_3333, 1'b0, 6'd0, 36'h0, 4'b0001);
    rd(6'd1, 6'd0, "R5");
  endtask

  task automatic t_lane8;
    wr(1'b1, 6'd2, 36'h1_2345_6789, 1'b0, 6'd0, 36'h0, 4'b0101);
    rd(6'd2, 6'd1, "R1");
    wr(1'b1, 6'd2, 36'hE_DCBA_9876, 1'b0, 6'd0, 36'h0, 4'b1000);
    rd(6'd2, 6'd1, "R1");
    wr(1'b1, 6'd6, 36'h0_0000_0000, 1'b0, 6'd0, 36'h0, 4'b1110);
    rd(6'd6, 6'd2, "R5");
  endtask

  task automatic t_split;
    wr(1'b1, 6'd4, 36'hA_AAAA_AAAA, 1'b1, 6'd20, 36'h5_5555_5555, 4'b0110);
    rd(6'd4, 6'd20, "R4");
    wr(1'b1, 6'd7, 36'hC_3C3C_3C3C, 1'b1, 6'd9, 36'h6_9696_9696, 4'b1001);
    rd(6'd7, 6'd9, "R4");
  endtask

  task automatic t_narrow;
    wr(1'b1, 6'd10, 36'h0_0000_01FF, 1'b1, 6'd11, 36'h0_0000_0000, 4'b0001);
    rd(6'd10, 6'd11, "R3");
    wr(1'b1, 6'd10, 36'h0_0000_0000, 1'b1, 6'd11, 36'h0_0000_01FF, 4'b0100);
    rd(6'd10, 6'd11, "R3");
  endtask

  task automatic t_we_low;
    wr(1'b0, 6'd12, 36'h0_0000_0000, 1'b0, 6'd13, 36'h0_0000_0000, 4'hF);
    rd(6'd12, 6'd13, "R6");
  endtask

  task automatic t_pipe;
    rd(6'd14, 6'd15, "R7");
    @(negedge clk);
    a_addr = 6'd16;
    @(negedge clk);
    chk("R7", {18'h0, qa18}, {18'h0, sh18[14]});
    chk("R7", {4'h0, qa32}, {4'h0, sh32[14]});
    a_addr = 6'd17;
    @(negedge clk);
    chk("R7", {18'h0, qa18}, {18'h0, sh18[16]});
    chk("R7", {4'h0, qa32}, {4'h0, sh32[16]});
    @(negedge clk);
    chk("R7", {27'h0, qa9}, {27'h0, sh9[17]});
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 1'b0;
    a_we = 1'b1; a_addr = 6'd3; a_wd = 36'h0_0000_0000; be = 4'hF;
    b_we = 1'b1; b_addr = 6'd5; b_wd = 36'h0_0000_0000;
    repeat (3) @(negedge clk);
    chk("R9", {18'h0, qa18}, 36'h0);
    chk("R9", {27'h0, qa9}, 36'h0);
    rst_n = 1'b1; a_we = 1'b0; b_we = 1'b0; be = 4'h0;
    repeat (4) @(negedge clk);
    rd(6'd3, 6'd5, "R9");
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    a_we = 1'b0; b_we = 1'b0; a_addr = '0; b_addr = '0;
    a_wd = '0; b_wd = '0; be = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    t_reset_state();
    t_init();
    t_lane9();
    t_lane8();
    t_split();
    t_narrow();
    t_we_low();
    t_pipe();
    t_reset_again();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule